// File: doc/BRIEF.md
# Watchdog Timer with Power-of-Two Postscaler

This block is a watchdog that counts ticks of a slow free-running oscillator. A fixed prescaler turns every 128 ticks into one base period, which is nominally 4 ms. A postscaler counts base periods. A 4-bit select picks the timeout as 2^s base periods, so the timeout runs from 4 ms up to about 131 s. If the count runs out, the block raises a single-cycle request: a wake-up when the device is asleep, and a device reset otherwise.

Software keeps the watchdog quiet by clearing it often enough. Several other events also restart the count: entering sleep, a change of the oscillator frequency select, a detected clock failure, and device reset. The watchdog is enabled by the configuration bit. The software enable bit can only switch it on when the configuration bit leaves it off. The block outputs the resulting enable so that the slow oscillator runs whenever the watchdog needs it.

Top module: `wdog_core`

## Requirements
- R1: The prescaler counts ticks on `osc_tick` only (cycles with `osc_tick` low do not count). With `ps_sel` = 0, a timeout request rises on the clock edge that samples the 128th tick after the count was cleared.
- R2: A `ps_sel` value s (0 to 15) sets the timeout to 128 * 2^s ticks.
- R3: The effective enable is `cfg_en` OR `sw_en`. `osc_en` shows it. Either bit alone runs the watchdog.
- R4: While the effective enable is low, both counters stay at zero and no request is raised. After the watchdog is re-enabled, a full timeout is needed.
- R5: A `clr_wdt` pulse restarts the count from zero.
- R6: A `sleep_enter` pulse restarts the count from zero.
- R7: Any change of `fsel` from its value in the previous cycle restarts the count from zero.
- R8: A `clk_fail` pulse restarts the count from zero.
- R9: If a clear and an expiry fall in the same cycle, the clear wins. No request is raised and a full timeout follows.
- R10: A timeout raises `wake_req` if `asleep` was high in the expiry cycle, and `rst_req` otherwise. Each request is high for exactly one cycle, and the two are never high together.
- R11: After a timeout both counters restart from zero, so the next timeout comes one full period later.
- R12: Synchronous active-low `rst_n` clears both counters and drives both requests low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low device reset |
| osc_tick | input | 1 | One-cycle tick from the slow internal oscillator |
| cfg_en | input | 1 | Configuration enable for the watchdog |
| sw_en | input | 1 | Software enable, effective only while cfg_en is low |
| ps_sel | input | 4 | Postscaler select s, timeout = 2^s base periods |
| fsel | input | 3 | Oscillator frequency select; any change clears the count |
| clr_wdt | input | 1 | Clear pulse from the clear-watchdog instruction |
| sleep_enter | input | 1 | Clear pulse on sleep entry |
| clk_fail | input | 1 | Clear pulse on detected clock failure |
| asleep | input | 1 | Device is in a power-managed sleep mode |
| osc_en | output | 1 | Request to keep the slow oscillator running |
| rst_req | output | 1 | One-cycle device reset request on timeout while awake |
| wake_req | output | 1 | One-cycle wake-up request on timeout while asleep |

## Verification
The two functions that can land in one cycle are a clear and the expiry of the count. The bench clears the watchdog and feeds exactly one tick fewer than the timeout. It then asserts `clr_wdt` in the very cycle that samples the final tick. The test passes only if no request appears on that edge and the next request needs a full fresh period. A design that let expiry win would raise a request at once. A design that merged the two events would instead show a shortened second period.

// File: rtl/wdog_pkg.sv
// Package: shared types and helpers for the watchdog.
// Assumes: the postscaler select is an unsigned power-of-two exponent.
package wdog_pkg;

    // Clear sources, gathered so they can be reduced in one place
    typedef struct packed {
        logic instr;
        logic sleep;
        logic freq;
        logic fail;
    } wdog_clr_t;

    // True when any clear source is active
    function automatic logic wdog_any_clear(input wdog_clr_t c);
        return c.instr | c.sleep | c.freq | c.fail;
    endfunction

endpackage

// File: rtl/wdog_clear_gen.sv
// Module: merges every count-clearing event into a single clear.
// A change of the oscillator frequency select is found by comparing the
// input with a copy registered one cycle earlier.
// Assumes: the other sources are one-cycle pulses synchronous to clk.
module wdog_clear_gen
    import wdog_pkg::*;
#(
    parameter int FSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FSEL_W-1:0] fsel,
    input  logic              clr_wdt,
    input  logic              sleep_enter,
    input  logic              clk_fail,
    output logic              clr_any
);

    logic [FSEL_W-1:0] fsel_q;
    wdog_clr_t         src;

    // Keep the previous frequency select; reset loads the live value so reset makes no clear of its own
    always_ff @(posedge clk) begin
        fsel_q <= fsel;
    end

    // Collect the clear sources
    always_comb begin
        src.instr = clr_wdt;
        src.sleep = sleep_enter;
        src.freq  = rst_n && (fsel != fsel_q);
        src.fail  = clk_fail;
    end

    // Reduce to one clear
    assign clr_any = wdog_any_clear(src);

endmodule

// File: rtl/wdog_prescale.sv
// Module: fixed divider from oscillator ticks to base-period pulses.
// Emits base_pulse in the cycle that samples the last tick of a period.
// Assumes: PRE_DIV >= 2; a clear or disable has priority over counting.
module wdog_prescale #(
    parameter int PRE_DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic clr,
    input  logic tick,
    output logic base_pulse
);

    localparam int            CNT_W = $clog2(PRE_DIV);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PRE_DIV - 1);

    logic [CNT_W-1:0] cnt;

    // Final tick of a base period while running and not being cleared
    assign base_pulse = en && !clr && tick && (cnt == LAST);

    // Count ticks, wrap at the end of a period, hold at zero when idle or cleared
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr) begin
            cnt <= '0;
        end else if (base_pulse) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_postscale.sv
// Module: counts base periods and flags expiry after 2^sel of them.
// Tap k is true when the low k bits of the count are all ones, so the
// next base pulse completes 2^k periods; tap 0 is always true.
// Assumes: base_pulse is already gated by enable and clear.
module wdog_postscale #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic             base_pulse,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);

    localparam int TAPS  = 2 ** SEL_W;
    localparam int CNT_W = TAPS - 1;

    logic [CNT_W-1:0] pcnt;
    logic [TAPS-1:0]  tap;

    // One tap per selectable ratio
    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        if (k == 0) begin : g_first
            assign tap[k] = 1'b1;
        end else begin : g_rest
            assign tap[k] = &pcnt[k-1:0];
        end
    end

    // Select the tap and qualify with the base pulse
    assign expire = base_pulse && tap[sel];

    // Count base periods; restart on expiry, clear or disable
    always_ff @(posedge clk) begin
        if (!rst_n || !en || clr || expire) begin
            pcnt <= '0;
        end else if (base_pulse) begin
            pcnt <= pcnt + 1'b1;
        end
    end

endmodule

// File: rtl/wdog_core.sv
// Module: top of the watchdog. Resolves the enable, wires clear generation,
// the prescaler and the postscaler, and routes expiry to a reset or a
// wake-up request registered for one cycle.
// Assumes: osc_tick and all pulses are synchronous to clk; rst_n is the
// device reset and is synchronous, active low.
module wdog_core #(
    parameter int PRE_DIV = 128,
    parameter int SEL_W   = 4,
    parameter int FSEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              cfg_en,
    input  logic              sw_en,
    input  logic [SEL_W-1:0]  ps_sel,
    input  logic [FSEL_W-1:0] fsel,
    input  logic              clr_wdt,
    input  logic              sleep_enter,
    input  logic              clk_fail,
    input  logic              asleep,
    output logic              osc_en,
    output logic              rst_req,
    output logic              wake_req
);

    logic en_eff;
    logic clr_any;
    logic base_pulse;
    logic expire;

    // Software bit only matters while the configuration bit is off
    assign en_eff = cfg_en ? 1'b1 : sw_en;
    assign osc_en = en_eff;

    wdog_clear_gen #(
        .FSEL_W (FSEL_W)
    ) i_clear (
        .clk         (clk),
        .rst_n       (rst_n),
        .fsel        (fsel),
        .clr_wdt     (clr_wdt),
        .sleep_enter (sleep_enter),
        .clk_fail    (clk_fail),
        .clr_any     (clr_any)
    );

    wdog_prescale #(
        .PRE_DIV (PRE_DIV)
    ) i_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_eff),
        .clr        (clr_any),
        .tick       (osc_tick),
        .base_pulse (base_pulse)
    );

    wdog_postscale #(
        .SEL_W (SEL_W)
    ) i_post (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_eff),
        .clr        (clr_any),
        .base_pulse (base_pulse),
        .sel        (ps_sel),
        .expire     (expire)
    );

    // Register the request, steered by the sleep state of the expiry cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req  <= 1'b0;
            wake_req <= 1'b0;
        end else begin
            rst_req  <= expire && !asleep;
            wake_req <= expire && asleep;
        end
    end

endmodule

// File: rtl/wdog_core_chk.sv
// Module: property checker for wdog_core, attached with bind.
// Assumes: the same clock and synchronous reset as the design.
module wdog_core_chk #(
    parameter int PRE_DIV = 128
) (
    input logic clk,
    input logic rst_n,
    input logic clr_wdt,
    input logic sleep_enter,
    input logic clk_fail,
    input logic asleep,
    input logic osc_en,
    input logic rst_req,
    input logic wake_req
);

    localparam int GAP_W = $clog2(PRE_DIV + 1) + 1;

    logic [GAP_W-1:0] gap;

    // Cycles since reset or the last request, saturating at PRE_DIV
    always_ff @(posedge clk) begin
        if (!rst_n || rst_req || wake_req) begin
            gap <= GAP_W'(1);
        end else if (gap < GAP_W'(PRE_DIV)) begin
            gap <= gap + 1'b1;
        end
    end

    // R10: never both requests at once
    assert_one_kind_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_req, wake_req}));

    // R10: requests last one cycle
    assert_rst_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    assert_wake_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |=> !wake_req);

    // R10: kind follows the sleep state one cycle earlier
    assert_wake_asleep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(asleep));
    assert_rst_awake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(asleep));

    // R9: a clear suppresses a request on the next edge
    assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wdt || sleep_enter || clk_fail) |=> !(rst_req || wake_req));

    // R4: disabled watchdog raises nothing
    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> !(rst_req || wake_req));

    // R1: requests are at least one base period apart
    assert_min_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req || wake_req) |-> (gap >= GAP_W'(PRE_DIV)));

endmodule

bind wdog_core wdog_core_chk #(
    .PRE_DIV (PRE_DIV)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_wdt     (clr_wdt),
    .sleep_enter (sleep_enter),
    .clk_fail    (clk_fail),
    .asleep      (asleep),
    .osc_en      (osc_en),
    .rst_req     (rst_req),
    .wake_req    (wake_req)
);

// File: tb/test_wdog_core.sv
// Directed bench for wdog_core: one task per scenario, each self-checking.
module test_wdog_core;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b0;
    logic       cfg_en = 1'b1;
    logic       sw_en = 1'b0;
    logic [3:0] ps_sel = 4'd0;
    logic [2:0] fsel = 3'd0;
    logic       clr_wdt = 1'b0;
    logic       sleep_enter = 1'b0;
    logic       clk_fail = 1'b0;
    logic       asleep = 1'b0;
    logic       osc_en;
    logic       rst_req;
    logic       wake_req;

    int vec = 0;
    int bad = 0;

    wdog_core i_wdog_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .osc_tick    (osc_tick),
        .cfg_en      (cfg_en),
        .sw_en       (sw_en),
        .ps_sel      (ps_sel),
        .fsel        (fsel),
        .clr_wdt     (clr_wdt),
        .sleep_enter (sleep_enter),
        .clk_fail    (clk_fail),
        .asleep      (asleep),
        .osc_en      (osc_en),
        .rst_req     (rst_req),
        .wake_req    (wake_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // One clock edge with the given tick value, ending at a falling edge
    task automatic step(input bit tk);
        osc_tick = tk;
        @(negedge clk);
        osc_tick = 1'b0;
    endtask

    // Run ticks every div cycles and expect a request after n ticks
    task automatic expect_timeout(input int n, input int div, input bit wake, input string req);
        int ticks = 0;
        int found = 0;
        for (int i = 1; i <= n * div + 4 && found == 0; i++) begin
            bit tk = ((i % div) == 0);
            ticks += int'(tk);
            step(tk);
            if (rst_req || wake_req) begin
                found = 1;
                check(ticks == n, req, "ticks to timeout", ticks, n);
                check(wake_req == wake && rst_req == !wake, req, "request kind {rst,wake}",
                      int'({rst_req, wake_req}), wake ? 1 : 2);
            end
        end
        if (found == 0) check(1'b0, req, "timeout seen", 0, 1);
        step(1'b0);
        check(!(rst_req || wake_req), req, "request width", int'({rst_req, wake_req}), 0);
    endtask

    // Feed n ticks and require silence throughout
    task automatic run_quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            step(1'b1);
            if (rst_req || wake_req) seen++;
        end
        check(seen == 0, req, "requests while quiet", seen, 0);
    endtask

    // Apply one clear source for one edge: 0 instr, 1 sleep, 2 freq, 3 fail
    task automatic apply_clear(input int src, input bit tk);
        case (src)
            0: clr_wdt = 1'b1;
            1: sleep_enter = 1'b1;
            2: fsel = fsel + 3'd1;
            default: clk_fail = 1'b1;
        endcase
        step(tk);
        clr_wdt = 1'b0;
        sleep_enter = 1'b0;
        clk_fail = 1'b0;
    endtask

    task automatic t_reset_r12();
        rst_n = 1'b0;
        repeat (3) step(1'b1);
        check(!rst_req && !wake_req, "R12", "requests in reset", int'({rst_req, wake_req}), 0);
        rst_n = 1'b1;
        expect_timeout(BASE, 1, 1'b0, "R12");
        run_quiet(60, "R12");
        rst_n = 1'b0;
        step(1'b1);
        rst_n = 1'b1;
        check(!rst_req && !wake_req, "R12", "requests after mid reset", int'({rst_req, wake_req}), 0);
        expect_timeout(BASE, 1, 1'b0, "R12");
    endtask

    task automatic t_base_r1();
        apply_clear(0, 1'b1);
        expect_timeout(BASE, 1, 1'b0, "R1");
        apply_clear(0, 1'b1);
        expect_timeout(BASE, 3, 1'b0, "R1");
    endtask

    task automatic t_postscale_r2();
        ps_sel = 4'd1;
        apply_clear(0, 1'b1);
        expect_timeout(BASE * 2, 1, 1'b0, "R2");
        ps_sel = 4'd3;
        apply_clear(0, 1'b1);
        expect_timeout(BASE * 8, 1, 1'b0, "R2");
        ps_sel = 4'd0;
    endtask

    task automatic t_restart_r11();
        apply_clear(0, 1'b1);
        expect_timeout(BASE, 1, 1'b0, "R11");
        expect_timeout(BASE, 1, 1'b0, "R11");
    endtask

    task automatic t_enable_r3();
        cfg_en = 1'b1; sw_en = 1'b0;
        step(1'b0);
        check(osc_en == 1'b1, "R3", "osc_en cfg only", int'(osc_en), 1);
        cfg_en = 1'b0; sw_en = 1'b1;
        step(1'b0);
        check(osc_en == 1'b1, "R3", "osc_en sw only", int'(osc_en), 1);
        apply_clear(0, 1'b1);
        expect_timeout(BASE, 1, 1'b0, "R3");
        cfg_en = 1'b1; sw_en = 1'b0;
    endtask

    task automatic t_disable_r4();
        cfg_en = 1'b0; sw_en = 1'b0;
        step(1'b0);
        check(osc_en == 1'b0, "R4", "osc_en off", int'(osc_en), 0);
        run_quiet(400, "R4");
        sw_en = 1'b1;
        expect_timeout(BASE, 1, 1'b0, "R4");
        run_quiet(60, "R4");
        sw_en = 1'b0;
        repeat (2) step(1'b1);
        sw_en = 1'b1;
        expect_timeout(BASE, 1, 1'b0, "R4");
        cfg_en = 1'b1; sw_en = 1'b0;
    endtask

    task automatic t_clear_src(input int src, input string req);
        apply_clear(0, 1'b1);
        run_quiet(60, req);
        apply_clear(src, 1'b1);
        expect_timeout(BASE, 1, 1'b0, req);
    endtask

    task automatic t_race_r9();
        apply_clear(0, 1'b1);
        run_quiet(BASE - 1, "R9");
        apply_clear(0, 1'b1);
        check(!(rst_req || wake_req), "R9", "request on clear edge", int'({rst_req, wake_req}), 0);
        expect_timeout(BASE, 1, 1'b0, "R9");
    endtask

    task automatic t_sleep_r10();
        asleep = 1'b1;
        apply_clear(0, 1'b1);
        expect_timeout(BASE, 1, 1'b1, "R10");
        asleep = 1'b0;
        expect_timeout(BASE, 1, 1'b0, "R10");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog all-R actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_r12();
        t_base_r1();
        t_postscale_r2();
        t_restart_r11();
        t_enable_r3();
        t_disable_r4();
        t_clear_src(0, "R5");
        t_clear_src(1, "R6");
        t_clear_src(2, "R7");
        t_clear_src(3, "R8");
        t_race_r9();
        t_sleep_r10();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule